// File: doc/BRIEF.md
# Triggered Snapshot Capture Engine

This block sits behind a sample detector and keeps a circular buffer of the most recent input samples. The buffer is written on every valid sample, so earlier samples are already stored when an event arrives. When an event is accepted, the block keeps a set number of samples from before the trigger point and collects a set number from after it. It then freezes the buffer and exposes the record, together with a header, until a consumer releases it.

The trigger has two possible sources. One is level qualification: the sample level must stay above a threshold for a run of consecutive samples, and shorter runs are treated as glitches. The other is an external sync pulse, with a programmable timeout that forces a self-triggered record when the pulse does not arrive. After a record is released, a hold-off of valid samples must pass before the block re-arms. Events that complete while the block is not armed are counted as missed. Every cycle spent not armed is counted as dead time.

Top module: `snap_capture`

## Requirements
- R1: Every valid sample is written to a ring of 2^AW entries, except while a record is ready. A record holds `pre_len` samples that come before the trigger sample, followed by the trigger sample and the next `post_len`-1 samples. `rd_data` returns record entry `rd_idx`, where index 0 is the oldest sample.
- R2: With `ext_mode`=0, an event qualifies on the valid sample that completes a run of `dwell_len` consecutive valid samples strictly above `thresh`. A `dwell_len` of 0 acts as 1. A run that ends before that length produces no record and changes neither count.
- R3: `hdr_ts` holds the `timestamp` value of the first sample of the qualifying run. In external mode it holds the value of the trigger sample.
- R4: `hdr_band`, `hdr_gain` and `hdr_temp` hold the values present on the trigger sample.
- R5: `hdr_ovl` is 1 if and only if `near_fs` was set on at least one sample inside the record window, counting pre-trigger, trigger and post-trigger samples.
- R6: `capture_active` is 1 from the cycle after the trigger sample is accepted until the last post-trigger sample is accepted. After that, `rec_ready` is 1 and the header and buffer stay frozen until `rec_ack` is seen. The two flags are never 1 together.
- R7: After `rec_ack`, the block re-arms only when `holdoff_len` further valid samples have passed. An event that completes during this time produces no record.
- R8: `fired_cnt` increments once for each accepted trigger. `missed_cnt` increments once for each event that completes while the block is not armed. This includes an event that completes on the last post-trigger sample.
- R9: `cfg_err` is 1 when `post_len` is 0 or when `pre_len`+`post_len` exceeds 2^AW. While it is 1, no trigger is accepted. A sum equal to 2^AW is allowed.
- R10: With `ext_mode`=1, a valid sample that carries `ext_trig` is the trigger sample, and level qualification is ignored.
- R11: With `ext_mode`=1 and `ext_timeout`=N>0, if `ext_trig` has not arrived, the N-th valid sample counted since the block became armed in external mode forces a trigger, and `hdr_tmo` is set to 1. A record started by `ext_trig` has `hdr_tmo`=0.
- R12: `dead_cnt` counts clock cycles in which the block is not armed, and it saturates. It stays constant while the block is armed. After reset it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| s_valid | input | 1 | Sample strobe |
| s_data | input | DW | Sample level |
| near_fs | input | 1 | Sample is near full scale |
| thresh | input | DW | Qualification threshold |
| dwell_len | input | DLW | Required run length |
| holdoff_len | input | HW | Re-arm hold-off in samples |
| pre_len | input | AW+1 | Pre-trigger samples |
| post_len | input | AW+1 | Trigger plus post-trigger samples |
| ext_mode | input | 1 | Select external trigger source |
| ext_trig | input | 1 | External sync trigger |
| ext_timeout | input | HW | External fallback timeout, 0 disables |
| timestamp | input | TW | Free-running time |
| band | input | BW | Band state |
| gain | input | GW | Gain state |
| temp | input | TPW | Temperature word |
| rd_idx | input | AW | Record read index |
| rec_ack | input | 1 | Release the ready record |
| rec_ready | output | 1 | Record frozen and readable |
| rd_data | output | DW | Record sample at rd_idx |
| hdr_ts | output | TW | Header timestamp |
| hdr_band | output | BW | Header band |
| hdr_gain | output | GW | Header gain |
| hdr_temp | output | TPW | Header temperature |
| hdr_ovl | output | 1 | Header overload flag |
| hdr_tmo | output | 1 | Header timeout flag |
| capture_active | output | 1 | Post-trigger window in progress |
| cfg_err | output | 1 | Window configuration invalid |
| fired_cnt | output | CW | Accepted triggers |
| missed_cnt | output | CW | Events while not armed |
| dead_cnt | output | DTW | Cycles not armed |

## Verification
A second run can complete its dwell on the very sample that closes the post-trigger window of the record already in progress. In that case the last post-trigger sample and a qualified event arrive in the same cycle. The bench provokes this by starting the second pulse exactly dwell-length samples before the end of the window. It then judges the outcome: there must be a single record whose final entries hold the second pulse, `missed_cnt` must go up by one, and `fired_cnt` must go up only for the first event. The same kind of collision is forced at the edge of the hold-off, with a run placed just after release.

// File: rtl/snap_capture.sv
module snap_capture #(
  parameter int DW  = 12,
  parameter int AW  = 5,
  parameter int TW  = 16,
  parameter int DLW = 6,
  parameter int HW  = 8,
  parameter int CW  = 8,
  parameter int DTW = 16,
  parameter int BW  = 3,
  parameter int GW  = 4,
  parameter int TPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           s_valid,
  input  logic [DW-1:0]  s_data,
  input  logic           near_fs,
  input  logic [DW-1:0]  thresh,
  input  logic [DLW-1:0] dwell_len,
  input  logic [HW-1:0]  holdoff_len,
  input  logic [AW:0]    pre_len,
  input  logic [AW:0]    post_len,
  input  logic           ext_mode,
  input  logic           ext_trig,
  input  logic [HW-1:0]  ext_timeout,
  input  logic [TW-1:0]  timestamp,
  input  logic [BW-1:0]  band,
  input  logic [GW-1:0]  gain,
  input  logic [TPW-1:0] temp,
  input  logic [AW-1:0]  rd_idx,
  input  logic           rec_ack,
  output logic           rec_ready,
  output logic [DW-1:0]  rd_data,
  output logic [TW-1:0]  hdr_ts,
  output logic [BW-1:0]  hdr_band,
  output logic [GW-1:0]  hdr_gain,
  output logic [TPW-1:0] hdr_temp,
  output logic           hdr_ovl,
  output logic           hdr_tmo,
  output logic           capture_active,
  output logic           cfg_err,
  output logic [CW-1:0]  fired_cnt,
  output logic [CW-1:0]  missed_cnt,
  output logic [DTW-1:0] dead_cnt
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [1:0] {ARMED, POST, HELD, HOLDOFF} st_t;
  st_t st;

  logic [DW-1:0]  mem [DEPTH];
  logic [AW-1:0]  wp, start;
  logic [AW:0]    rem, nf_age;
  logic           nf_seen;
  logic [HW-1:0]  hcnt, tcnt;
  logic [DLW-1:0] run;
  logic [TW-1:0]  run_ts;

  logic [AW+1:0]  win_len;
  logic [DLW-1:0] dwell_m1;
  logic above, qual, tmo_hit, trig, miss_ev, wr, pre_ovl;

  assign win_len  = {1'b0, pre_len} + {1'b0, post_len};
  assign cfg_err  = (post_len == '0) || (win_len > (AW+2)'(DEPTH));
  assign above    = s_data > thresh;
  assign dwell_m1 = (dwell_len == '0) ? '0 : dwell_len - DLW'(1);
  assign qual     = s_valid && above && (run == dwell_m1);
  assign tmo_hit  = ext_mode && (ext_timeout != '0) && (tcnt == ext_timeout - HW'(1));
  assign trig     = (st == ARMED) && !cfg_err && s_valid && (ext_mode ? (ext_trig || tmo_hit) : qual);
  assign miss_ev  = (st != ARMED) && s_valid && (ext_mode ? ext_trig : qual);
  assign wr       = s_valid && (st != HELD);
  assign pre_ovl  = nf_seen && (nf_age < pre_len);

  assign rec_ready      = (st == HELD);
  assign capture_active = (st == POST);
  assign rd_data        = mem[start + rd_idx];

  always_ff @(posedge clk)
    if (wr) mem[wp] <= s_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ARMED;
      wp <= '0; start <= '0; rem <= '0;
      nf_age <= '0; nf_seen <= 1'b0;
      hcnt <= '0; tcnt <= '0; run <= '0; run_ts <= '0;
      hdr_ts <= '0; hdr_band <= '0; hdr_gain <= '0; hdr_temp <= '0;
      hdr_ovl <= 1'b0; hdr_tmo <= 1'b0;
      fired_cnt <= '0; missed_cnt <= '0; dead_cnt <= '0;
    end else begin
      if (wr) wp <= wp + AW'(1);

      if (s_valid) begin
        if (above) begin
          if (run != '1) run <= run + DLW'(1);
          if (run == '0) run_ts <= timestamp;
        end else run <= '0;
      end

      if (st != ARMED || !ext_mode) tcnt <= '0;
      else if (s_valid) tcnt <= tcnt + HW'(1);

      if (wr) begin
        if (near_fs) begin
          nf_age <= '0;
          nf_seen <= 1'b1;
        end else if (nf_age != (AW+1)'(DEPTH)) nf_age <= nf_age + (AW+1)'(1);
      end

      if (miss_ev) missed_cnt <= missed_cnt + CW'(1);
      if (st != ARMED && dead_cnt != '1) dead_cnt <= dead_cnt + DTW'(1);

      case (st)
        ARMED: if (trig) begin
          start     <= wp - pre_len[AW-1:0];
          hdr_ts    <= (ext_mode || run == '0) ? timestamp : run_ts;
          hdr_band  <= band;
          hdr_gain  <= gain;
          hdr_temp  <= temp;
          hdr_tmo   <= ext_mode && !ext_trig;
          hdr_ovl   <= near_fs || pre_ovl;
          fired_cnt <= fired_cnt + CW'(1);
          rem       <= post_len - (AW+1)'(1);
          st        <= (post_len == (AW+1)'(1)) ? HELD : POST;
        end
        POST: if (s_valid) begin
          hdr_ovl <= hdr_ovl || near_fs;
          if (rem == (AW+1)'(1)) st <= HELD;
          else rem <= rem - (AW+1)'(1);
        end
        HELD: if (rec_ack) begin
          hcnt <= '0;
          st   <= (holdoff_len == '0) ? ARMED : HOLDOFF;
        end
        default: if (s_valid) begin
          if (hcnt == holdoff_len - HW'(1)) st <= ARMED;
          else hcnt <= hcnt + HW'(1);
        end
      endcase
    end
  end

  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(capture_active && rec_ready));

  a_r6_frozen_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rec_ready && !rec_ack |=> rec_ready && $stable(hdr_ts) && $stable(hdr_ovl) && $stable(hdr_band));

  a_r8_fire_only_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_cnt != $past(fired_cnt)) |-> $past(st == ARMED));

  a_r8_miss_only_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (missed_cnt != $past(missed_cnt)) |-> $past(st != ARMED));

  a_r9_no_trigger_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ARMED) && cfg_err |=> fired_cnt == $past(fired_cnt));

  a_r12_dead_stable_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ARMED) |=> $stable(dead_cnt));
endmodule

// File: tb/snap_capture_test.sv
module snap_capture_test;
  localparam int PERIOD = 10;
  localparam int DW = 12, AW = 5, TW = 16, DLW = 6, HW = 8, CW = 8, DTW = 16, BW = 3, GW = 4, TPW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_valid = 1'b0, near_fs = 1'b0, ext_mode = 1'b0, ext_trig = 1'b0, rec_ack = 1'b0;
  logic [DW-1:0] s_data = '0, thresh = 12'd200;
  logic [DLW-1:0] dwell_len = 6'd3;
  logic [HW-1:0] holdoff_len = 8'd8, ext_timeout = 8'd12;
  logic [AW:0] pre_len = 6'd4, post_len = 6'd6;
  logic [TW-1:0] timestamp = '0;
  logic [BW-1:0] band = '0;
  logic [GW-1:0] gain = '0;
  logic [TPW-1:0] temp = '0;
  logic [AW-1:0] rd_idx = '0;
  logic rec_ready, hdr_ovl, hdr_tmo, capture_active, cfg_err;
  logic [DW-1:0] rd_data;
  logic [TW-1:0] hdr_ts;
  logic [BW-1:0] hdr_band;
  logic [GW-1:0] hdr_gain;
  logic [TPW-1:0] hdr_temp;
  logic [CW-1:0] fired_cnt, missed_cnt;
  logic [DTW-1:0] dead_cnt;

  snap_capture uut (.*);

  always #(PERIOD/2) clk = ~clk;

  typedef struct { int tidx; int pre; int post; int ts; int bnd; int gn; int tp; int ovl; int tmo; } rec_t;
  rec_t exp_q[$];
  int hist [0:8191];
  int nidx = 0, nchk = 0, nerr = 0, recs_done = 0;

  task automatic chk(string req, string what, int act, int expv);
    nchk++;
    if (act != expv) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push(int d, bit nf = 1'b0, bit et = 1'b0);
    s_valid = 1'b1; s_data = DW'(d); near_fs = nf; ext_trig = et;
    timestamp = TW'(nidx + 1000);
    hist[nidx] = d; nidx++;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) push(10 + nidx % 37);
  endtask

  task automatic pulse(int len);
    for (int i = 0; i < len; i++) push(300 + i);
  endtask

  task automatic expect_rec(int tidx, int tsidx, int ovl, int tmo);
    rec_t e;
    e.tidx = tidx; e.pre = int'(pre_len); e.post = int'(post_len); e.ts = tsidx + 1000;
    e.bnd = int'(band); e.gn = int'(gain); e.tp = int'(temp); e.ovl = ovl; e.tmo = tmo;
    exp_q.push_back(e);
  endtask

  // monitor: pops expected records and compares header and samples
  initial begin
    rec_t e;
    forever begin
      @(negedge clk);
      if (rec_ready) begin
        if (exp_q.size() == 0) chk("R8", "unexpected record", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk("R3", "hdr_ts", int'(hdr_ts), e.ts);
          chk("R4", "hdr_band", int'(hdr_band), e.bnd);
          chk("R4", "hdr_gain", int'(hdr_gain), e.gn);
          chk("R4", "hdr_temp", int'(hdr_temp), e.tp);
          chk("R5", "hdr_ovl", int'(hdr_ovl), e.ovl);
          chk("R11", "hdr_tmo", int'(hdr_tmo), e.tmo);
          for (int i = 0; i < e.pre + e.post; i++) begin
            rd_idx = AW'(i);
            #1;
            chk("R1", $sformatf("entry %0d", i), int'(rd_data), hist[e.tidx - e.pre + i]);
            @(negedge clk);
          end
        end
        rec_ack = 1'b1;
        @(negedge clk);
        rec_ack = 1'b0;
        recs_done++;
      end
    end
  end

  initial begin
    #(PERIOD * 150000);
    chk("R1", "watchdog expired", 1, 0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int s, t, d0, rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6", "reset rec_ready", int'(rec_ready), 0);
    chk("R6", "reset capture_active", int'(capture_active), 0);
    chk("R8", "reset fired_cnt", int'(fired_cnt), 0);
    chk("R8", "reset missed_cnt", int'(missed_cnt), 0);
    chk("R9", "cfg_err valid config", int'(cfg_err), 0);
    idle(40);
    d0 = int'(dead_cnt);
    chk("R12", "dead_cnt after reset", d0, 0);
    idle(10);
    chk("R12", "dead_cnt stable armed", int'(dead_cnt), d0);

    // S1: plain level trigger, header captured at trigger sample
    band = 3'd2; gain = 4'd5; temp = 8'd77;
    s = nidx;
    pulse(3);
    expect_rec(s + 2, s, 0, 0);
    chk("R6", "capture_active after trigger", int'(capture_active), 1);
    band = 3'd6; gain = 4'd1; temp = 8'd9;
    idle(4);
    chk("R6", "capture_active mid window", int'(capture_active), 1);
    chk("R6", "rec_ready mid window", int'(rec_ready), 0);
    idle(1);
    chk("R6", "capture_active after last post", int'(capture_active), 0);
    chk("R6", "rec_ready after last post", int'(rec_ready), 1);
    idle(40);
    chk("R8", "fired after S1", int'(fired_cnt), 1);
    chk("R12", "dead_cnt grew", int'(dead_cnt > DTW'(d0)), 1);

    // S2: glitch shorter than dwell
    pulse(2);
    idle(40);
    chk("R2", "fired after glitch", int'(fired_cnt), 1);
    chk("R2", "missed after glitch", int'(missed_cnt), 0);

    // S3: overload inside pre window (oldest pre entry)
    s = nidx;
    push(10, 1'b1); push(11); pulse(3);
    expect_rec(s + 4, s + 2, 1, 0);
    idle(40);
    // S3b: overload one sample before the pre window
    s = nidx;
    push(12, 1'b1); push(13); push(14); pulse(3);
    expect_rec(s + 5, s + 3, 0, 0);
    idle(40);
    // S3c: overload on last post sample
    s = nidx;
    pulse(3); idle(4); push(15, 1'b1);
    expect_rec(s + 2, s, 1, 0);
    idle(40);

    // S4: second dwell completes on the last post sample
    s = nidx;
    pulse(3); idle(2); pulse(3);
    expect_rec(s + 2, s, 0, 0);
    idle(40);
    chk("R8", "fired after collision", int'(fired_cnt), 5);
    chk("R8", "missed after collision", int'(missed_cnt), 1);

    // S5: event inside hold-off
    rd = recs_done;
    s = nidx;
    pulse(3);
    expect_rec(s + 2, s, 0, 0);
    while (recs_done <= rd) idle(1);
    pulse(3);
    idle(40);
    chk("R7", "fired after holdoff event", int'(fired_cnt), 6);
    chk("R7", "missed after holdoff event", int'(missed_cnt), 2);
    s = nidx;
    pulse(3);
    expect_rec(s + 2, s, 0, 0);
    idle(40);

    // S6: configuration errors and exact-depth window
    post_len = 6'd0;
    idle(1);
    chk("R9", "cfg_err post zero", int'(cfg_err), 1);
    pulse(3); idle(40);
    chk("R9", "fired with cfg_err", int'(fired_cnt), 7);
    pre_len = 6'd20; post_len = 6'd13;
    idle(1);
    chk("R9", "cfg_err oversize", int'(cfg_err), 1);
    pre_len = 6'd20; post_len = 6'd12;
    idle(1);
    chk("R9", "cfg_err full depth", int'(cfg_err), 0);
    idle(30);
    s = nidx;
    pulse(3);
    expect_rec(s + 2, s, 0, 0);
    idle(80);
    chk("R9", "fired full depth", int'(fired_cnt), 8);
    pre_len = 6'd4; post_len = 6'd6;
    idle(10);

    // S7: external trigger, level ignored
    ext_mode = 1'b1;
    s = nidx;
    pulse(3); idle(2); push(16, 1'b0, 1'b1);
    ext_mode = 1'b0;
    expect_rec(s + 5, s + 5, 0, 0);
    idle(40);
    chk("R10", "fired after ext", int'(fired_cnt), 9);

    // S8: external timeout fallback
    ext_mode = 1'b1;
    s = nidx;
    idle(11);
    chk("R11", "no trigger before timeout", int'(capture_active), 0);
    idle(1);
    chk("R11", "trigger at timeout", int'(capture_active), 1);
    ext_mode = 1'b0;
    expect_rec(s + 11, s + 11, 0, 1);
    idle(40);
    chk("R11", "fired after timeout", int'(fired_cnt), 10);

    idle(20);
    chk("R1", "all records delivered", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule